// File: doc/BRIEF.md
# Power-Sourcing Port Sequencer

This block steps one power-sourcing port through its life cycle. The cycle starts in an idle state and moves to detection evaluation. From there the port either runs a classification step or takes its power demand from another source. A budget check then either grants power or denies it. A granted port passes through a current-limited startup phase and then stays powered.

The analog front end is represented here by digital summary inputs:
- a detection-complete strobe and a signature-valid flag;
- a classification-complete strobe and a class code;
- a power-budget code;
- a maintain-power-signature flag.

The block drives the port power switch enable and the inrush-limit mode. It also reports the state code and the latched demand. Classification time, startup limit time and signature dropout time are counted inside the block, with parameterised lengths.

Two further paths exist. A user-allocation path loads the power demand and the class directly and skips classification. A test force path, taken only from a dedicated local pin, powers the port without detection. That path ends after a parameterised maximum time.

States:
- IDLE (0)
- DETECT (1)
- CLASS (2)
- DENIED (3)
- START (4)
- POWERED (5)
- FORCE (6)

Transitions:
- IDLE→FORCE
- IDLE→DETECT
- DETECT→IDLE, when the port is disabled or the signature is invalid
- DETECT→CLASS
- DETECT→START
- DETECT→DENIED
- CLASS→START
- CLASS→DENIED
- CLASS→IDLE, on disable or timeout
- DENIED→IDLE
- START→POWERED
- START→IDLE, on disable
- POWERED→IDLE, on disable, budget shortfall or dropout
- FORCE→IDLE, on release or time limit

Top module: `pse_power_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `state_code` is 0 (IDLE), and both `pwr_en` and `inrush_mode` are 0.
- R2: State codes are IDLE=0, DETECT=1, CLASS=2, DENIED=3, START=4, POWERED=5 and FORCE=6. IDLE moves to DETECT when `port_en` is high. In DETECT, a `det_done` with `sig_valid` low returns to IDLE. Without `det_done` the state holds. No exit toward CLASS, START or DENIED happens without `sig_valid`.
- R3: `budget_code` gives the available power:
  - 0 gives P_C1;
  - 1 gives P_C2;
  - 2 gives P_C4;
  - 3 gives `user_budget`.
  With the default parameters these values are 40, 70 and 300.
- R4: When classification is skipped, the port goes to START only if the available power is strictly greater than the demand. Otherwise it goes to DENIED, and equality also denies. Without user allocation the demand is P_C3 (154) and `class_reg` becomes 0.
- R5: With `user_alloc` high, classification is skipped even if `do_class` is high. `req_pwr` and `class_reg` load from `user_req_pwr` and `user_class`.
- R6: With `do_class` high and `user_alloc` low, DETECT goes to CLASS. There, `class_done` latches `class_code` into `class_reg` and sets `req_pwr` from the class:
  - class 1 gives 40;
  - class 2 gives 70;
  - class 4 gives 300;
  - class 0, class 3 and codes 5 to 7 give 154.
  The same strict budget rule then chooses START or DENIED.
- R7: Every entry into CLASS restarts the classification timer. If no `class_done` arrives in T_CLASS cycles, the port returns to IDLE.
- R8: DENIED lasts exactly one cycle and then goes to IDLE.
- R9: START holds `pwr_en` and `inrush_mode` high for exactly T_INRUSH cycles. It then enters POWERED, where `inrush_mode` is 0.
- R10: In POWERED, T_MPDO consecutive cycles with `mps_present` low remove power and return to IDLE. Any cycle with `mps_present` high restarts that count.
- R11: In POWERED, an available power below `req_pwr` returns the port to IDLE on the next edge.
- R12: In IDLE, a high `test_force` enters FORCE, which has priority over `port_en`. FORCE drives `pwr_en` high with no detection, and lowering `test_force` returns to IDLE.
- R13: FORCE lasts at most T_FORCE cycles and then returns to IDLE. It cannot be re-entered until `test_force` has been low for at least one cycle.
- R14: A low `port_en` in DETECT, CLASS, START or POWERED returns the port to IDLE on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable for normal operation |
| test_force | input | 1 | Local test pin requesting forced power |
| det_done | input | 1 | Detection evaluation result ready |
| sig_valid | input | 1 | Detection signature is valid |
| do_class | input | 1 | Run classification after detection |
| class_done | input | 1 | Classification result ready |
| class_code | input | 3 | Measured class, 0 to 4 |
| user_alloc | input | 1 | Take demand and class from the user inputs |
| user_req_pwr | input | PW | User-assigned power demand |
| user_class | input | 3 | User-assigned class |
| budget_code | input | 2 | Available power budget code |
| user_budget | input | PW | Budget value used when the code is 3 |
| mps_present | input | 1 | Maintain-power signature seen |
| pwr_en | output | 1 | Port power switch enable |
| inrush_mode | output | 1 | Startup current-limit mode |
| force_active | output | 1 | Test force mode active |
| state_code | output | 3 | Current state code |
| req_pwr | output | PW | Latched power demand |
| class_reg | output | 3 | Latched class |

## Verification
The bench sets PW=9 and shortens the timers to T_CLASS=4, T_INRUSH=3, T_MPDO=5 and T_FORCE=6. With these values, the classification timeout, the exact startup length, the dropout restart on a returning signature and the force time limit with its lockout all occur within a few cycles of each scenario. The bench also checks cycle by cycle that the time limits fall on the exact cycle. The power values keep their defaults. This places the boundaries within reach:
- a user budget equal to the demand;
- class 4 against the class-4 budget;
- a budget drop below the demand while powered.

// File: rtl/pse_pkg.sv
package pse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DETECT  = 3'd1,
        ST_CLASS   = 3'd2,
        ST_DENIED  = 3'd3,
        ST_START   = 3'd4,
        ST_POWERED = 3'd5,
        ST_FORCE   = 3'd6
    } pse_state_e;

    typedef enum logic [1:0] {
        BUD_LOW   = 2'd0,
        BUD_MID   = 2'd1,
        BUD_HIGH  = 2'd2,
        BUD_USER  = 2'd3
    } pse_budget_e;

endpackage

// File: rtl/pse_timer.sv
// Up-counter that restarts while clr is high and flags the LEN-th cycle.
module pse_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);

    logic [CW-1:0] cnt_q;

    assign done = (cnt_q == CW'(LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/pse_budget.sv
// Decodes the budget code and maps a class code to its power demand.
module pse_budget #(
    parameter int PW   = 9,
    parameter int P_C1 = 40,
    parameter int P_C2 = 70,
    parameter int P_C3 = 154,
    parameter int P_C4 = 300
) (
    input  logic [1:0]    budget_code,
    input  logic [PW-1:0] user_budget,
    input  logic [2:0]    class_code,
    output logic [PW-1:0] avail_pwr,
    output logic [PW-1:0] class_pwr
);
    import pse_pkg::*;

    always_comb begin
        unique case (pse_budget_e'(budget_code))
            BUD_LOW:  avail_pwr = PW'(P_C1);
            BUD_MID:  avail_pwr = PW'(P_C2);
            BUD_HIGH: avail_pwr = PW'(P_C4);
            BUD_USER: avail_pwr = user_budget;
            default:  avail_pwr = PW'(P_C1);
        endcase
    end

    always_comb begin
        case (class_code)
            3'd1:    class_pwr = PW'(P_C1);
            3'd2:    class_pwr = PW'(P_C2);
            3'd4:    class_pwr = PW'(P_C4);
            default: class_pwr = PW'(P_C3);
        endcase
    end
endmodule

// File: rtl/pse_req_latch.sv
// Holds the power demand and class chosen for the current attempt.
module pse_req_latch #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_class,
    input  logic          load_user,
    input  logic          load_dflt,
    input  logic [2:0]    class_code,
    input  logic [PW-1:0] class_pwr,
    input  logic [2:0]    user_class,
    input  logic [PW-1:0] user_req_pwr,
    input  logic [PW-1:0] dflt_pwr,
    output logic [PW-1:0] req_pwr,
    output logic [2:0]    class_reg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_pwr   <= '0;
            class_reg <= '0;
        end else if (load_class) begin
            req_pwr   <= class_pwr;
            class_reg <= class_code;
        end else if (load_user) begin
            req_pwr   <= user_req_pwr;
            class_reg <= user_class;
        end else if (load_dflt) begin
            req_pwr   <= dflt_pwr;
            class_reg <= 3'd0;
        end
    end
endmodule

// File: rtl/pse_power_ctrl.sv
module pse_power_ctrl
    import pse_pkg::*;
#(
    parameter int PW       = 9,
    parameter int T_CLASS  = 1000,
    parameter int T_INRUSH = 5000,
    parameter int T_MPDO   = 30000,
    parameter int T_FORCE  = 100000,
    parameter int P_C1     = 40,
    parameter int P_C2     = 70,
    parameter int P_C3     = 154,
    parameter int P_C4     = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          test_force,
    input  logic          det_done,
    input  logic          sig_valid,
    input  logic          do_class,
    input  logic          class_done,
    input  logic [2:0]    class_code,
    input  logic          user_alloc,
    input  logic [PW-1:0] user_req_pwr,
    input  logic [2:0]    user_class,
    input  logic [1:0]    budget_code,
    input  logic [PW-1:0] user_budget,
    input  logic          mps_present,
    output logic          pwr_en,
    output logic          inrush_mode,
    output logic          force_active,
    output logic [2:0]    state_code,
    output logic [PW-1:0] req_pwr,
    output logic [2:0]    class_reg
);
    localparam logic [PW-1:0] DFLT_PWR = PW'(P_C3);

    pse_state_e    state_q, state_d;
    logic          force_lock_q;
    logic          force_timeout;
    logic          ld_class, ld_user, ld_dflt;
    logic [PW-1:0] avail_pwr, class_pwr, skip_req;
    logic          cls_done, inr_done, mpdo_done, frc_done;

    pse_budget #(
        .PW(PW), .P_C1(P_C1), .P_C2(P_C2), .P_C3(P_C3), .P_C4(P_C4)
    ) u_budget (
        .budget_code (budget_code),
        .user_budget (user_budget),
        .class_code  (class_code),
        .avail_pwr   (avail_pwr),
        .class_pwr   (class_pwr)
    );

    pse_req_latch #(.PW(PW)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_class   (ld_class),
        .load_user    (ld_user),
        .load_dflt    (ld_dflt),
        .class_code   (class_code),
        .class_pwr    (class_pwr),
        .user_class   (user_class),
        .user_req_pwr (user_req_pwr),
        .dflt_pwr     (DFLT_PWR),
        .req_pwr      (req_pwr),
        .class_reg    (class_reg)
    );

    // Each timer restarts whenever its owning state is not active.
    pse_timer #(.LEN(T_CLASS)) u_tmr_class (
        .clk (clk), .rst_n (rst_n),
        .clr (state_q != ST_CLASS), .done (cls_done)
    );

    pse_timer #(.LEN(T_INRUSH)) u_tmr_inrush (
        .clk (clk), .rst_n (rst_n),
        .clr (state_q != ST_START), .done (inr_done)
    );

    pse_timer #(.LEN(T_MPDO)) u_tmr_mpdo (
        .clk (clk), .rst_n (rst_n),
        .clr ((state_q != ST_POWERED) || mps_present), .done (mpdo_done)
    );

    pse_timer #(.LEN(T_FORCE)) u_tmr_force (
        .clk (clk), .rst_n (rst_n),
        .clr (state_q != ST_FORCE), .done (frc_done)
    );

    assign skip_req = user_alloc ? user_req_pwr : DFLT_PWR;

    // Next-state and load decisions.
    always_comb begin
        state_d       = state_q;
        ld_class      = 1'b0;
        ld_user       = 1'b0;
        ld_dflt       = 1'b0;
        force_timeout = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (test_force && !force_lock_q) begin
                    state_d = ST_FORCE;
                end else if (port_en) begin
                    state_d = ST_DETECT;
                end
            end
            ST_DETECT: begin
                if (!port_en) begin
                    state_d = ST_IDLE;
                end else if (det_done) begin
                    if (!sig_valid) begin
                        state_d = ST_IDLE;
                    end else if (do_class && !user_alloc) begin
                        state_d = ST_CLASS;
                    end else begin
                        ld_user = user_alloc;
                        ld_dflt = !user_alloc;
                        state_d = (avail_pwr > skip_req) ? ST_START : ST_DENIED;
                    end
                end
            end
            ST_CLASS: begin
                if (!port_en) begin
                    state_d = ST_IDLE;
                end else if (class_done) begin
                    ld_class = 1'b1;
                    state_d  = (avail_pwr > class_pwr) ? ST_START : ST_DENIED;
                end else if (cls_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_DENIED: begin
                state_d = ST_IDLE;
            end
            ST_START: begin
                if (!port_en) begin
                    state_d = ST_IDLE;
                end else if (inr_done) begin
                    state_d = ST_POWERED;
                end
            end
            ST_POWERED: begin
                if (!port_en || (avail_pwr < req_pwr) ||
                    (mpdo_done && !mps_present)) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FORCE: begin
                if (!test_force) begin
                    state_d = ST_IDLE;
                end else if (frc_done) begin
                    state_d       = ST_IDLE;
                    force_timeout = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and force lockout.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            force_lock_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!test_force) begin
                force_lock_q <= 1'b0;
            end else if (force_timeout) begin
                force_lock_q <= 1'b1;
            end
        end
    end

    // Moore outputs.
    always_comb begin
        pwr_en       = 1'b0;
        inrush_mode  = 1'b0;
        force_active = 1'b0;
        unique case (state_q)
            ST_START: begin
                pwr_en      = 1'b1;
                inrush_mode = 1'b1;
            end
            ST_POWERED: pwr_en = 1'b1;
            ST_FORCE: begin
                pwr_en       = 1'b1;
                force_active = 1'b1;
            end
            default: ;
        endcase
        state_code = state_q;
    end
endmodule

// File: rtl/pse_power_ctrl_chk.sv
module pse_power_ctrl_chk #(
    parameter int PW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    state_code,
    input logic          sig_valid,
    input logic          test_force,
    input logic          pwr_en,
    input logic          inrush_mode,
    input logic [PW-1:0] avail_pwr,
    input logic [PW-1:0] req_pwr
);
    AST_DETECT_NEEDS_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && !sig_valid) |=> (state_code == 3'd0 || state_code == 3'd1)); // R2

    AST_DENIED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3) |=> (state_code == 3'd0)); // R8

    AST_INRUSH_WITH_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        inrush_mode |-> pwr_en); // R9

    AST_POWERED_VIA_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5) |-> ($past(state_code) == 3'd4 || $past(state_code) == 3'd5)); // R9

    AST_BUDGET_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5 && avail_pwr < req_pwr) |=> (state_code == 3'd0)); // R11

    AST_FORCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd6 && !test_force) |=> (state_code == 3'd0)); // R12

    AST_FORCE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd6) |-> ($past(state_code) == 3'd0 || $past(state_code) == 3'd6)); // R12
endmodule

bind pse_power_ctrl pse_power_ctrl_chk #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_code  (state_code),
    .sig_valid   (sig_valid),
    .test_force  (test_force),
    .pwr_en      (pwr_en),
    .inrush_mode (inrush_mode),
    .avail_pwr   (avail_pwr),
    .req_pwr     (req_pwr)
);

// File: tb/pse_power_ctrl_tb.sv
module pse_power_ctrl_tb;
    localparam int PW = 9;
    localparam int TC = 4;
    localparam int TI = 3;
    localparam int TM = 5;
    localparam int TF = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic port_en = 0, test_force = 0, det_done = 0, sig_valid = 0;
    logic do_class = 0, class_done = 0, user_alloc = 0, mps_present = 0;
    logic [2:0] class_code = 0, user_class = 0;
    logic [1:0] budget_code = 0;
    logic [PW-1:0] user_req_pwr = 0, user_budget = 0;
    logic pwr_en, inrush_mode, force_active;
    logic [2:0] state_code, class_reg;
    logic [PW-1:0] req_pwr;

    pse_power_ctrl #(
        .PW(PW), .T_CLASS(TC), .T_INRUSH(TI), .T_MPDO(TM), .T_FORCE(TF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .test_force(test_force),
        .det_done(det_done), .sig_valid(sig_valid), .do_class(do_class),
        .class_done(class_done), .class_code(class_code), .user_alloc(user_alloc),
        .user_req_pwr(user_req_pwr), .user_class(user_class),
        .budget_code(budget_code), .user_budget(user_budget),
        .mps_present(mps_present), .pwr_en(pwr_en), .inrush_mode(inrush_mode),
        .force_active(force_active), .state_code(state_code),
        .req_pwr(req_pwr), .class_reg(class_reg)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit finished = 0;

    typedef struct packed {
        logic [2:0]    st;
        logic          pw;
        logic          inr;
        logic [PW-1:0] rq;
    } exp_t;
    exp_t exp_q[$];

    // Reference model built from the requirements.
    logic [2:0]    m_st = 0;
    int            m_cnt = 0, m_drop = 0;
    logic          m_lock = 0;
    logic [PW-1:0] m_req = 0;

    function automatic logic [PW-1:0] class_w(input logic [2:0] c);
        case (c)
            3'd1: return 40;
            3'd2: return 70;
            3'd4: return 300;
            default: return 154;
        endcase
    endfunction

    function automatic logic [PW-1:0] budget_w(input logic [1:0] b, input logic [PW-1:0] u);
        case (b)
            2'd0: return 40;
            2'd1: return 70;
            2'd2: return 300;
            default: return u;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_drop = 0; m_lock = 0; m_req = 0;
        end else begin
            logic [2:0] nx;
            logic [PW-1:0] av;
            logic tmo;
            exp_t e;
            nx = m_st; tmo = 0;
            av = budget_w(budget_code, user_budget);
            case (m_st)
                3'd0: if (test_force && !m_lock) nx = 6; else if (port_en) nx = 1;
                3'd1: if (!port_en) nx = 0;
                      else if (det_done) begin
                          if (!sig_valid) nx = 0;
                          else if (do_class && !user_alloc) nx = 2;
                          else begin
                              m_req = user_alloc ? user_req_pwr : 154;
                              nx = (av > m_req) ? 3'd4 : 3'd3;
                          end
                      end
                3'd2: if (!port_en) nx = 0;
                      else if (class_done) begin
                          m_req = class_w(class_code);
                          nx = (av > m_req) ? 3'd4 : 3'd3;
                      end else if (m_cnt == TC - 1) nx = 0;
                3'd3: nx = 0;
                3'd4: if (!port_en) nx = 0; else if (m_cnt == TI - 1) nx = 5;
                3'd5: if (!port_en || av < m_req || (!mps_present && m_drop == TM - 1)) nx = 0;
                3'd6: if (!test_force) nx = 0;
                      else if (m_cnt == TF - 1) begin nx = 0; tmo = 1; end
                default: nx = 0;
            endcase
            if (!test_force) m_lock = 0; else if (tmo) m_lock = 1;
            m_drop = (m_st != 5 || mps_present) ? 0 : m_drop + 1;
            m_cnt  = (nx == m_st) ? m_cnt + 1 : 0;
            m_st   = nx;
            e.st = nx;
            e.pw = (nx == 4 || nx == 5 || nx == 6);
            e.inr = (nx == 4);
            e.rq = m_req;
            exp_q.push_back(e);
        end
    end

    // Monitor: compares each produced cycle against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (state_code !== e.st || pwr_en !== e.pw || inrush_mode !== e.inr || req_pwr !== e.rq) begin
                errors++;
                $display("FAIL %s state=%0d pwr=%0b inr=%0b req=%0d expected state=%0d pwr=%0b inr=%0b req=%0d",
                         tag, state_code, pwr_en, inrush_mode, req_pwr, e.st, e.pw, e.inr, e.rq);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic idle_out();
        port_en = 0; class_done = 0; cyc(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R1 state", state_code, 0);
        chk("R1 pwr_en", pwr_en, 0);
        chk("R1 inrush", inrush_mode, 0);
        rst_n = 1;
        cyc(1);
        chk("R1 after reset", state_code, 0);

        // R2: invalid signature bounces back to idle; no result holds DETECT
        tag = "R2"; port_en = 1; det_done = 1; sig_valid = 0;
        cyc(1); chk("R2 detect", state_code, 1);
        cyc(1); chk("R2 invalid sig", state_code, 0);
        det_done = 0; cyc(3); chk("R2 hold", state_code, 1);
        idle_out();

        // R4/R9: grant without classification
        tag = "R4"; budget_code = 2; sig_valid = 1; det_done = 1; mps_present = 1; port_en = 1;
        cyc(2); chk("R9 start inrush", inrush_mode, 1);
        cyc(6); chk("R9 powered", state_code, 5);
        chk("R9 inrush off", inrush_mode, 0);
        chk("R4 req default", req_pwr, 154);
        chk("R4 class zero", class_reg, 0);

        // R11: budget shrink while powered
        tag = "R11"; budget_code = 0;
        cyc(1); chk("R11 off", state_code, 0); chk("R11 pwr", pwr_en, 0);
        idle_out();

        // R4/R8: equal budget is denied
        tag = "R4"; budget_code = 3; user_budget = 154; port_en = 1;
        cyc(2); chk("R4 equal denied", state_code, 3);
        tag = "R8";
        cyc(1); chk("R8 denied to idle", state_code, 0);
        idle_out();

        // R5/R3: user allocation
        tag = "R5"; user_alloc = 1; do_class = 1; user_req_pwr = 60; user_class = 5;
        budget_code = 1; port_en = 1;
        cyc(8); chk("R5 powered", state_code, 5);
        chk("R5 req", req_pwr, 60); chk("R5 class", class_reg, 5);
        idle_out();
        tag = "R3"; budget_code = 0; port_en = 1;
        cyc(2); chk("R3 low budget denied", state_code, 3);
        idle_out(); user_alloc = 0;

        // R6: classification path
        tag = "R6"; do_class = 1; class_code = 2; budget_code = 2; port_en = 1;
        cyc(2); chk("R6 in class", state_code, 2);
        class_done = 1;
        cyc(1); chk("R6 to start", state_code, 4);
        class_done = 0;
        cyc(6); chk("R6 powered", state_code, 5);
        chk("R6 req", req_pwr, 70); chk("R6 class", class_reg, 2);
        idle_out();
        class_code = 4; class_done = 1; port_en = 1;
        cyc(3); chk("R6 class4 equal denied", state_code, 3);
        idle_out();

        // R7: classification timeout
        tag = "R7"; port_en = 1;
        cyc(5); chk("R7 still class", state_code, 2);
        cyc(1); chk("R7 timeout", state_code, 0);
        idle_out(); do_class = 0;

        // R10: dropout with restart
        tag = "R10"; budget_code = 2; port_en = 1; mps_present = 1;
        cyc(8);
        mps_present = 0; cyc(3); mps_present = 1; cyc(1);
        chk("R10 restart", state_code, 5);
        mps_present = 0; cyc(4); chk("R10 before limit", state_code, 5);
        cyc(1); chk("R10 dropout", state_code, 0);
        idle_out(); mps_present = 1;

        // R14: disable during startup
        tag = "R14"; port_en = 1;
        cyc(3); chk("R14 in start", state_code, 4);
        port_en = 0; cyc(1); chk("R14 disabled", state_code, 0);
        cyc(2);

        // R12/R13: force path
        tag = "R12"; sig_valid = 0; det_done = 0; test_force = 1;
        cyc(1); chk("R12 force", state_code, 6); chk("R12 pwr", pwr_en, 1);
        tag = "R13";
        cyc(5); chk("R13 last force", state_code, 6);
        cyc(1); chk("R13 limit", state_code, 0);
        cyc(4); chk("R13 lockout", pwr_en, 0);
        test_force = 0; cyc(1);
        tag = "R12"; test_force = 1;
        cyc(1); chk("R12 reentry", force_active, 1);
        test_force = 0;
        cyc(1); chk("R12 release", state_code, 0);
        cyc(2);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule